// File: doc/BRIEF.md
# Restartable Streaming Counter Source

This block is a free-running source of incrementing counter values on a valid/ready output stream. A start strobe loads a caller-supplied initial value, and from the next cycle the block offers one beat per cycle whenever the consumer is ready. The count moves forward only when a beat is actually taken. Backpressure therefore never skips or repeats a value.

A run has no length limit. It ends only when a controller writes a one into a single-bit stop register through a small write port with a ready handshake. The block checks that port on every cycle, so a stop takes effect even while the output is stalled. When the stop is taken, a one-cycle done pulse is issued and the block goes idle. It can then be started again with a new initial value.

The first beat of every run carries a start-of-packet flag. A consumer can use it to find where a fresh run begins and to discard stale beats left over from an earlier run.

Top module: `restart_counter_src`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `out_valid_o` and `ctl_ready_o` are all low.
- R2: A start strobe while idle loads `start_value_i`. On the next cycle `busy_o` and `out_valid_o` are high, `out_data_o` equals the loaded value and `out_sop_o` is high.
- R3: The offered value rises by exactly one (modulo 2^DATA_W) after each cycle in which `out_valid_o` and `out_ready_i` are both high. On a cycle with `out_ready_i` low, the value and `out_valid_o` hold.
- R4: `out_sop_o` is high on the first beat of a run and low on every later beat of that run.
- R5: While running, `ctl_ready_o` is high. A write (`ctl_wr_i` high) with `ctl_wdata_i` = 1 is taken, and on the next cycle `out_valid_o` and `busy_o` are low.
- R6: A write with `ctl_wdata_i` = 0 is accepted with no effect. The run and its count continue.
- R7: A stop write is taken on the cycle it is presented, even while `out_ready_i` is low.
- R8: `done_o` is high for exactly one cycle: the cycle after a stop is taken.
- R9: A start strobe while running is ignored. The count continues with no reload and no start-of-packet.
- R10: While idle, `ctl_ready_o` is low and stop writes are ignored. A later start runs normally.
- R11: A beat accepted on the same cycle that a stop is taken completes normally, and no further beat is offered.
- R12: After a stop, a new start with a new value (for example 77) resumes the output from that value, and start-of-packet is set again.
- R13: With no stop, a run is unbounded, sustains one beat per cycle and wraps from 2^DATA_W-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, honoured only while idle |
| start_value_i | input | DATA_W | Initial value for the run |
| ctl_wr_i | input | 1 | Stop-register write request |
| ctl_wdata_i | input | 1 | Stop-register write data (1 = stop) |
| ctl_ready_o | output | 1 | Stop-register write accepted this cycle |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse after a stop is taken |
| out_valid_o | output | 1 | Output beat offered |
| out_ready_i | input | 1 | Consumer accepts the beat |
| out_data_o | output | DATA_W | Counter value |
| out_sop_o | output | 1 | First beat of the run |

## Verification
The bench uses a 10-bit configuration and compares every offered beat against an arithmetic model of the expected count.

Output ready patterns:
- An always-ready output exercises the one-beat-per-cycle rate and the 7-to-263 sequence.
- A pseudo-random ready pattern shows that the count advances only on accepted beats and never on stalled cycles.

Stop writes are presented in three situations, each telling apart a different way of getting stop handling wrong:
- During a stall, which catches a stop that waits for backpressure to clear.
- Together with an accepted beat, which catches a lost final beat or an extra beat.
- While idle, which catches a stop that is latched before the run begins.

Start strobes are also sent during a run, where they must not reload the count. Runs from 77 and from near the top of the range check restart and wrap-around.

// File: rtl/restart_src_pkg.sv
package restart_src_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/rsc_stop_port.sv
module rsc_stop_port (
  input  logic running_i,
  input  logic ctl_wr_i,
  input  logic ctl_wdata_i,
  output logic ctl_ready_o,
  output logic stop_fire_o
);
  // The port is ready on every running cycle, whatever the output is doing.
  assign ctl_ready_o = running_i;
  assign stop_fire_o = ctl_wr_i & ctl_ready_o & ctl_wdata_i;
endmodule

// File: rtl/rsc_run_ctrl.sv
module rsc_run_ctrl
  import restart_src_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_fire_i,
  output logic running_o,
  output logic launch_o,
  output logic done_o
);
  run_state_e state_q;
  logic       done_q;

  assign running_o = (state_q == ST_RUN);
  assign launch_o  = (state_q == ST_IDLE) & start_i;
  assign done_o    = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) state_q <= ST_RUN;
        ST_RUN: begin
          if (stop_fire_i) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rsc_beat_counter.sv
module rsc_beat_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic [DATA_W-1:0] start_value_i,
  input  logic              beat_accept_i,
  output logic [DATA_W-1:0] count_o,
  output logic              first_o
);
  // Wraps modulo 2^DATA_W.
  function automatic logic [DATA_W-1:0] count_step(input logic [DATA_W-1:0] v);
    return v + {{(DATA_W-1){1'b0}}, 1'b1};
  endfunction

  logic [DATA_W-1:0] count_q;
  logic              first_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      first_q <= 1'b0;
    end else if (launch_i) begin
      count_q <= start_value_i;
      first_q <= 1'b1;
    end else if (beat_accept_i) begin
      count_q <= count_step(count_q);
      first_q <= 1'b0;
    end
  end

  assign count_o = count_q;
  assign first_o = first_q;
endmodule

// File: rtl/restart_counter_src.sv
module restart_counter_src #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] start_value_i,
  input  logic              ctl_wr_i,
  input  logic              ctl_wdata_i,
  output logic              ctl_ready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_sop_o
);
  // Named internal events, also observed by the bound checker.
  logic running;
  logic launch;
  logic stop_fire;
  logic beat_accept;
  logic first_beat;

  rsc_stop_port u_stop (
    .running_i   (running),
    .ctl_wr_i    (ctl_wr_i),
    .ctl_wdata_i (ctl_wdata_i),
    .ctl_ready_o (ctl_ready_o),
    .stop_fire_o (stop_fire)
  );

  rsc_run_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stop_fire_i (stop_fire),
    .running_o   (running),
    .launch_o    (launch),
    .done_o      (done_o)
  );

  assign out_valid_o = running;
  assign beat_accept = out_valid_o & out_ready_i;

  rsc_beat_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk           (clk),
    .rst_n         (rst_n),
    .launch_i      (launch),
    .start_value_i (start_value_i),
    .beat_accept_i (beat_accept),
    .count_o       (out_data_o),
    .first_o       (first_beat)
  );

  assign out_sop_o = first_beat;
  assign busy_o    = running;
endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [DATA_W-1:0] start_value_i,
  input logic              ctl_ready_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_sop_o,
  input logic              stop_fire
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!out_valid_o && !ctl_ready_o)); // R10
  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (out_valid_o && out_sop_o && out_data_o == $past(start_value_i))); // R2
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i && !stop_fire) |=> (out_valid_o && $stable(out_data_o))); // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i && !stop_fire) |=> (out_data_o == $past(out_data_o) + 1'b1)); // R3
  AST_SOP_FIRST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i) |=> !out_sop_o); // R4
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_fire |=> (!out_valid_o && !busy_o && done_o)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_RUN_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !stop_fire && !out_ready_i) |=> (busy_o && $stable(out_data_o))); // R9
endmodule

bind restart_counter_src rsc_checker #(.DATA_W(DATA_W)) u_rsc_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .start_value_i (start_value_i),
  .ctl_ready_o   (ctl_ready_o),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .out_valid_o   (out_valid_o),
  .out_ready_i   (out_ready_i),
  .out_data_o    (out_data_o),
  .out_sop_o     (out_sop_o),
  .stop_fire     (stop_fire)
);

// File: tb/test_restart_counter_src.sv
module test_restart_counter_src;
  localparam int W    = 10;
  localparam int MODV = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [W-1:0] start_value_i;
  logic         ctl_wr_i;
  logic         ctl_wdata_i;
  logic         ctl_ready_o;
  logic         busy_o;
  logic         done_o;
  logic         out_valid_o;
  logic         out_ready_i;
  logic [W-1:0] out_data_o;
  logic         out_sop_o;

  int total = 0;
  int bad   = 0;
  int exp_val;
  bit exp_sop;
  logic [7:0] lfsr = 8'hA5;

  always #2.5 clk = ~clk;

  restart_counter_src #(.DATA_W(W)) i_restart_counter_src (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .start_value_i (start_value_i),
    .ctl_wr_i      (ctl_wr_i),
    .ctl_wdata_i   (ctl_wdata_i),
    .ctl_ready_o   (ctl_ready_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .out_valid_o   (out_valid_o),
    .out_ready_i   (out_ready_i),
    .out_data_o    (out_data_o),
    .out_sop_o     (out_sop_o)
  );

  task automatic check(input string tag, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_start(input int v);
    start_value_i = W'(v);
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    exp_val = v % MODV;
    exp_sop = 1'b1;
  endtask

  // Runs n cycles. pat=1 drives a pseudo-random ready; every offered beat is compared.
  task automatic run_beats(input int n, input bit pat, input string tag);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready_i = pat ? (lfsr[0] | lfsr[2]) : 1'b1;
      #0;
      check({tag, " valid"}, int'(out_valid_o), 1);
      check({tag, " data"}, int'(out_data_o), exp_val);
      check({tag, " sop"}, int'(out_sop_o), int'(exp_sop));
      if (out_valid_o && out_ready_i) begin
        exp_val = (exp_val + 1) % MODV;
        exp_sop = 1'b0;
      end
      tick();
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; start_value_i = '0;
    ctl_wr_i = 1'b0; ctl_wdata_i = 1'b0; out_ready_i = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check("R1 busy", int'(busy_o), 0);
    check("R1 done", int'(done_o), 0);
    check("R1 valid", int'(out_valid_o), 0);
    check("R1 ctl_ready", int'(ctl_ready_o), 0);

    // R10 stop write while idle is refused and leaves no trace
    ctl_wr_i = 1'b1; ctl_wdata_i = 1'b1;
    #0 check("R10 ctl_ready idle", int'(ctl_ready_o), 0);
    tick();
    ctl_wr_i = 1'b0; ctl_wdata_i = 1'b0;
    check("R10 still idle", int'(busy_o), 0);
    check("R10 no valid idle", int'(out_valid_o), 0);

    // R2 start at 7
    do_start(7);
    check("R2 busy", int'(busy_o), 1);
    check("R2 valid", int'(out_valid_o), 1);
    check("R2 data", int'(out_data_o), 7);
    check("R2 sop", int'(out_sop_o), 1);
    check("R10 run after idle write", int'(ctl_ready_o), 1);

    // R3 R4 R13: 256 back-to-back beats 7..262, next is 263
    run_beats(256, 1'b0, "R13 full rate");
    check("R13 after 256 beats", int'(out_data_o), 263);

    // R9 start while running is ignored
    out_ready_i = 1'b0;
    start_value_i = W'(500); start_i = 1'b1;
    tick();
    start_i = 1'b0;
    check("R9 no reload", int'(out_data_o), 263);
    check("R9 no sop", int'(out_sop_o), 0);
    check("R9 busy", int'(busy_o), 1);

    // R6 writing zero keeps the run going
    ctl_wr_i = 1'b1; ctl_wdata_i = 1'b0; out_ready_i = 1'b1;
    #0 check("R6 ready", int'(ctl_ready_o), 1);
    tick();
    ctl_wr_i = 1'b0;
    exp_val = 264;
    check("R6 still busy", int'(busy_o), 1);
    check("R6 data", int'(out_data_o), 264);

    // R3 backpressure sweep
    run_beats(400, 1'b1, "R3 backpressure");

    // R3 stall holds, then R7 stop while stalled, R8 done pulse
    out_ready_i = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick();
      check("R3 stall hold", int'(out_data_o), exp_val);
      check("R3 stall valid", int'(out_valid_o), 1);
    end
    ctl_wr_i = 1'b1; ctl_wdata_i = 1'b1;
    #0 check("R7 ready while stalled", int'(ctl_ready_o), 1);
    tick();
    ctl_wr_i = 1'b0; ctl_wdata_i = 1'b0;
    check("R7 valid dropped", int'(out_valid_o), 0);
    check("R5 busy low", int'(busy_o), 0);
    check("R8 done high", int'(done_o), 1);
    tick();
    check("R8 done one cycle", int'(done_o), 0);

    // R12 restart at 77
    do_start(77);
    check("R12 data", int'(out_data_o), 77);
    check("R12 sop", int'(out_sop_o), 1);
    run_beats(300, 1'b1, "R12 run");

    // R11 stop on the same cycle as an accepted beat
    out_ready_i = 1'b1; ctl_wr_i = 1'b1; ctl_wdata_i = 1'b1;
    #0 check("R11 beat offered", int'(out_data_o), exp_val);
    tick();
    ctl_wr_i = 1'b0; ctl_wdata_i = 1'b0;
    check("R11 no further beat", int'(out_valid_o), 0);
    check("R11 done", int'(done_o), 1);
    for (int i = 0; i < 4; i++) begin
      tick();
      check("R11 stays idle", int'(out_valid_o), 0);
    end

    // R13 wrap from top of range
    do_start(MODV - 4);
    run_beats(8, 1'b0, "R13 wrap");
    check("R13 wrapped", int'(out_data_o), 4);
    ctl_wr_i = 1'b1; ctl_wdata_i = 1'b1;
    tick();
    ctl_wr_i = 1'b0;
    check("R5 stopped", int'(busy_o), 0);

    report();
  end
endmodule